// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 512K words by 8 bits. It accepts one single-word read or write at a time through a valid/ready handshake. It latches the address and the write data, and it drives the active-low chip-select, output-enable and write-enable strobes for whole numbers of clock cycles. It also controls the direction of the shared data lines and captures read data at the end of the access window. Each read result comes back on a one-cycle response pulse.

All strobe and recovery lengths come from nanosecond parameters and a clock-period parameter. Each one is rounded up to whole cycles when the design is elaborated, and each strobe phase lasts at least one cycle. A write is an overlap of chip-select and write-enable, and both strobes rise on the same edge. Output-enable stays high for the whole write. After a read, the controller waits for the bus-release time before it can turn its own data driver on, so the memory and the controller never drive the data lines at the same time. With the defaults (5 ns clock), a read holds its strobes for 4 cycles and the port is blocked for 2 more. A write pulse lasts 3 cycles, followed by 1 data-hold cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, chip-select, output-enable and write-enable are all high (inactive), the data driver is off, the request port is ready, and no response is signalled.
- R2: A request is taken only on a clock edge where both valid and ready are high. Ready goes low from the accept edge until the access and its recovery are over. With the defaults, ready returns 6 cycles after a read is accepted and 4 cycles after a write is accepted.
- R3: A read drives chip-select and output-enable low with write-enable high for exactly the read window. The window is the larger of the address-access and output-enable access counts, 4 cycles by default. The address stays stable throughout the window.
- R4: Read data is sampled on the edge that closes the read window. The response-valid output is high for exactly one cycle, in the cycle after that edge (4 edges after the accept edge by default), and carries the sampled byte.
- R5: A write holds chip-select and write-enable low together for the write window. The window is the largest of the write-pulse, address-to-end and data set-up counts, 3 cycles by default. Both strobes rise on the same edge, and output-enable stays high throughout.
- R6: During a write, the data driver is on from the first cycle of the write window through one hold cycle after the strobes rise. While the strobes rise, the driven byte and the address equal the accepted request.
- R7: The data driver is never on while output-enable is low. It turns on only after output-enable has been high for at least the bus-release count (2 cycles by default).
- R8: All 19 address bits reach the memory unchanged, including address 0 and address 0x7FFFF.
- R9: A write never produces a response pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Address lines to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data lines |
| mem_dq_drive | output | 1 | 1 = controller drives the data lines |
| mem_dq_in | input | 8 | Byte read from the data lines |

## Verification
The assertions check on every cycle that write-enable and output-enable are never low together, that the driver is never on while output-enable is low, that it turns on only after the bus-release count has run, that write-enable and chip-select rise together, that the address stays stable while an access is in flight, and that the response lasts one cycle. Only the bench scenarios can show end-to-end data correctness. The bench uses a memory model that presents valid data only after the strobes have been low for the access time, and compares read results against its own scoreboard. The bench scenarios also cover the exact window lengths, the handshake spacing and the boundary addresses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RECOV  = 3'd4
  } seq_state_e;

  // Round a nanosecond value up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 4,
  parameter int WR_CYC   = 3,
  parameter int RD_RECOV = 2,
  parameter int WR_RECOV = 0,
  parameter int TURN_CYC = 2,
  parameter int CNT_W    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_done,
  output logic busy,
  output logic cs_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_drive
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_q, cs_d;
  logic             oe_q, oe_d;
  logic             we_q, we_d;
  logic             drv_q, drv_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_done   = (state_q == ST_READ) && (cnt_q == '0);
  assign busy      = !req_ready;

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    cs_d    = cs_q;
    oe_d    = oe_q;
    we_d    = we_q;
    drv_d   = drv_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cs_d = 1'b0;
          if (req_write) begin
            state_d = ST_WPULSE;
            cnt_d   = CNT_W'(WR_CYC - 1);
            we_d    = 1'b0;
            drv_d   = 1'b1;
          end else begin
            state_d = ST_READ;
            cnt_d   = CNT_W'(RD_CYC - 1);
            oe_d    = 1'b0;
          end
        end
      end
      ST_READ: begin
        if (cnt_q == '0) begin
          cs_d = 1'b1;
          oe_d = 1'b1;
          if (RD_RECOV > 0) begin
            state_d = ST_RECOV;
            cnt_d   = CNT_W'(RD_RECOV - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WPULSE: begin
        if (cnt_q == '0) begin
          cs_d    = 1'b1;
          we_d    = 1'b1;
          state_d = ST_WHOLD;
        end
      end
      ST_WHOLD: begin
        drv_d = 1'b0;
        if (WR_RECOV > 0) begin
          state_d = ST_RECOV;
          cnt_d   = CNT_W'(WR_RECOV - 1);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RECOV: begin
        if (cnt_q == '0) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cs_d    = 1'b1;
        oe_d    = 1'b1;
        we_d    = 1'b1;
        drv_d   = 1'b0;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cs_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cs_q    <= cs_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      drv_q   <= drv_d;
    end
  end

  assign cs_n     = cs_q;
  assign oe_n     = oe_q;
  assign we_n     = we_q;
  assign dq_drive = drv_q;

  // Cycles that output-enable has been high, saturating at the release count
  logic [CNT_W-1:0] oe_hi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           oe_hi_q <= CNT_W'(TURN_CYC);
    else if (!oe_q)                       oe_hi_q <= '0;
    else if (oe_hi_q != CNT_W'(TURN_CYC)) oe_hi_q <= oe_hi_q + 1'b1;
  end

  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_q && !we_q));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> oe_q);

  p_drive_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> (oe_hi_q >= CNT_W'(TURN_CYC)));

  p_we_cs_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_q) |-> $rose(cs_q));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (cs_q && oe_q && we_q && !drv_q));

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_done,
  input  logic              busy,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rsp_q;

  // Next-state: clock enables written out
  always_comb begin
    addr_d  = accept  ? req_addr  : addr_q;
    wdata_d = accept  ? req_wdata : wdata_q;
    rdata_d = rd_done ? mem_dq_in : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      rsp_q   <= rd_done;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rdata_q;

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |=> !rsp_q);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_AA_NS   = 20,
  parameter int T_DOE_NS  = 8,
  parameter int T_RC_NS   = 20,
  parameter int T_HZOE_NS = 8,
  parameter int T_PWE_NS  = 13,
  parameter int T_AW_NS   = 13,
  parameter int T_SD_NS   = 9,
  parameter int T_WC_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int TURN_CYC = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int RD_RECOV = imax(TURN_CYC, ns_to_cyc(T_RC_NS, CLK_NS) - RD_CYC);
  localparam int WR_CYC   = imax(ns_to_cyc(T_PWE_NS, CLK_NS),
                                 imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)));
  localparam int WR_RECOV = imax(0, ns_to_cyc(T_WC_NS, CLK_NS) - WR_CYC - 1);
  localparam int MAX_CNT  = imax(imax(RD_CYC, WR_CYC), imax(RD_RECOV, imax(WR_RECOV, TURN_CYC)));
  localparam int CNT_W    = $clog2(MAX_CNT + 1);

  logic rst_sync_n;
  logic accept, rd_done, busy;

  sram_ctl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctl_seq #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .RD_RECOV (RD_RECOV),
    .WR_RECOV (WR_RECOV),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_done   (rd_done),
    .busy      (busy),
    .cs_n      (mem_cs_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_drive  (mem_dq_drive)
  );

  sram_ctl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .accept     (accept),
    .rd_done    (rd_done),
    .busy       (busy),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: tb/test_sram_async_ctl.sv
`timescale 1ns/1ps
module test_sram_async_ctl;

  localparam int RD_WIN   = 4;
  localparam int WR_WIN   = 3;
  localparam int TURN     = 2;
  localparam int RD_READY = 6;
  localparam int WR_READY = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_drive;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hA5;

  always #2.5 clk = ~clk;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 1'b0;
  bit cur_wr = 1'b0;
  logic [18:0] exp_addr;
  logic [7:0]  exp_wdata;
  logic [7:0]  sram_mem [int unsigned];
  logic [7:0]  ref_mem  [int unsigned];

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [7:0] ref_read(input logic [18:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model and strobe monitors, sampled at the falling edge
  int rd_lo = 0, we_lo = 0, oe_hi = TURN;
  logic [18:0] rd_addr;
  logic prev_drive = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (!mem_cs_n && !mem_oe_n) begin
        chk(mem_we_n == 1'b1, "R3", "we_n during read", mem_we_n, 1);
        if (rd_lo > 0 && mem_addr != rd_addr) rd_lo = 0;
        rd_lo++;
        rd_addr = mem_addr;
      end else if (rd_lo > 0) begin
        chk(rd_lo == RD_WIN, "R3", "read window", rd_lo, RD_WIN);
        rd_lo = 0;
      end
      mem_dq_in = (rd_lo >= RD_WIN)
                  ? (sram_mem.exists(rd_addr) ? sram_mem[rd_addr] : 8'h00) : 8'hA5;

      if (!mem_we_n) begin
        chk(!mem_cs_n && mem_oe_n && mem_dq_drive, "R5", "strobes in write",
            {mem_cs_n, mem_oe_n, mem_dq_drive}, 3'b011);
        we_lo++;
      end else if (we_lo > 0) begin
        chk(we_lo == WR_WIN, "R5", "write window", we_lo, WR_WIN);
        chk(mem_cs_n == 1'b1, "R5", "cs rises with we", mem_cs_n, 1);
        chk(mem_dq_drive == 1'b1, "R6", "drive in hold", mem_dq_drive, 1);
        chk(mem_dq_out == exp_wdata, "R6", "write data", mem_dq_out, exp_wdata);
        chk(mem_addr == exp_addr, "R8", "write address", mem_addr, exp_addr);
        sram_mem[mem_addr] = mem_dq_out;
        we_lo = 0;
      end

      if (mem_dq_drive && !prev_drive)
        chk(oe_hi >= TURN, "R7", "release before drive", oe_hi, TURN);
      if (mem_dq_drive && !mem_oe_n)
        chk(1'b0, "R7", "drive while oe low", 1, 0);
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      prev_drive = mem_dq_drive;

      if (cur_wr && rsp_valid) chk(1'b0, "R9", "response on write", 1, 0);
    end
  end

  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int acc;
    int t;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    cur_wr = wr; exp_addr = a; exp_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    acc = cyc;
    chk(req_ready == 1'b0, "R2", "ready after accept", req_ready, 0);
    if (!wr) begin
      t = 0;
      while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
      chk(cyc == acc + RD_WIN, "R4", "response cycle", cyc - acc, RD_WIN);
      chk(rsp_rdata == ref_read(a), "R4", "read data", rsp_rdata, ref_read(a));
      chk(mem_addr == a, "R8", "read address", mem_addr, a);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R4", "response one cycle", rsp_valid, 0);
    end
    while (!req_ready) @(negedge clk);
    chk(cyc == acc + (wr ? WR_READY : RD_READY), "R2", "ready spacing",
        cyc - acc, wr ? WR_READY : RD_READY);
    if (wr) ref_mem[a] = d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [18:0] pool [16];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes idle",
        {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_drive, "R1", "driver off", mem_dq_drive, 0);
    chk(req_ready, "R1", "ready", req_ready, 1);
    chk(!rsp_valid, "R1", "no response", rsp_valid, 0);
    mon_on = 1'b1;

    // R2: valid low is not accepted
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n, "R2", "no accept without valid", mem_cs_n, 1);

    // Directed: boundaries (R8), write-then-read, read-after-read, back-to-back writes
    run_op(1'b1, 19'h00000, 8'h3C);
    run_op(1'b1, 19'h7FFFF, 8'hC3);
    run_op(1'b0, 19'h7FFFF, 8'h00);
    run_op(1'b0, 19'h00000, 8'h00);
    run_op(1'b0, 19'h12345, 8'h00);
    run_op(1'b1, 19'h12345, 8'hFF);
    run_op(1'b1, 19'h12345, 8'h00);
    run_op(1'b0, 19'h12345, 8'h00);
    run_op(1'b1, 19'h55555, 8'hA5);
    run_op(1'b0, 19'h55555, 8'h00);

    // Random mix over a small address pool
    for (int i = 0; i < 16; i++) pool[i] = 19'($urandom);
    for (int i = 0; i < 300; i++) begin
      bit wr;
      logic [18:0] a;
      wr = 1'($urandom);
      a  = pool[$urandom % 16];
      run_op(wr, a, 8'($urandom));
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule